// File: doc/BRIEF.md
# Antenna Tuning Memory Lookup

This block holds stored matching-network presets for an automatic antenna tuner. Storage is a byte-wide array with one row per frequency segment and one column per antenna. Each cell is a 32-bit word kept as four bytes. A cell carries a 30-bit relay word and a validity flag. At reset every byte is erased to 0xFF, which marks the cell as empty.

A lookup takes a segment index and fetches all antenna cells of that row, one byte per cycle. It then picks an antenna that holds data. When more than one antenna holds data, the antenna used most recently is preferred; if that antenna holds no data, the lowest-numbered valid antenna is taken. The block returns the antenna number and its relay word, or raises a miss flag. A write stores a new relay word into one cell after a successful tune, again one byte per cycle.

Top module: `tune_store`

## Requirements
- R1: Asynchronous active-low reset clears `busy`, `done`, `miss`, `hit_ant` and `hit_relay` to zero, and it erases every cell to all ones. A lookup made just after reset therefore misses.
- R2: When the block is idle and `wr_start` is sampled high, it latches `wr_seg`, `wr_ant` and `wr_relay`. `busy` is then high for exactly four cycles while the four bytes are stored. The stored word has bit 31 = 0 (valid), bit 30 = 0 and bits 29:0 = relay word, least significant byte first at byte address (segment*ANT_N+antenna)*4.
- R3: When the block is idle and `lk_start` is sampled high, `busy` is high for 17 cycles (16 byte reads, then one decision cycle). After that, `done` is high for exactly one cycle, with `busy` low.
- R4: If exactly one antenna of the segment holds a valid cell, the lookup returns that antenna in `hit_ant` and its relay bits in `hit_relay`, with `miss` = 0.
- R5: If several antennas hold valid cells and the last-used antenna is one of them, the last-used antenna is returned.
- R6: If several antennas hold valid cells and the last-used antenna is not one of them, the lowest-numbered valid antenna is returned.
- R7: If no antenna of the segment holds a valid cell, `miss` = 1, `hit_ant` = 0 and `hit_relay` = 0.
- R8: The last-used antenna is set to the written antenna by every accepted write and to the returned antenna by every hitting lookup. A missing lookup leaves it unchanged. After reset it is antenna 0.
- R9: `wr_start` and `lk_start` are ignored while `busy` is high. They store nothing and produce no extra `done`.
- R10: If `wr_start` and `lk_start` are sampled high in the same idle cycle, the write is performed and the lookup is dropped, so no `done` follows.
- R11: `hit_ant`, `hit_relay` and `miss` change only in the cycle in which `done` is high, and they hold otherwise.
- R12: Writing a cell that already holds data replaces its relay word, and later lookups return the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_start | input | 1 | Start a lookup for `lk_seg` |
| lk_seg | input | SEG_W | Frequency segment to look up |
| wr_start | input | 1 | Start storing a cell |
| wr_seg | input | SEG_W | Segment of the cell to store |
| wr_ant | input | ANT_W | Antenna of the cell to store |
| wr_relay | input | 30 | Relay word to store |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when lookup results are updated |
| hit_ant | output | ANT_W | Antenna chosen by the last lookup |
| hit_relay | output | 30 | Relay word of the chosen antenna |
| miss | output | 1 | Last lookup found no valid cell |

## Verification
A write request and a lookup request can land in the same cycle. They can do so either when both are raised together while the block is idle, or when one arrives while the other is still being processed. The bench raises both strobes together from idle and checks three things: `busy` lasts exactly the four write cycles, no `done` appears over the following cycles, and a later lookup returns the written word. It also raises both strobes partway through a running lookup. It then checks that only the one expected `done` arrives on time, and that the intruding write left no trace in the lookups that follow.

// File: rtl/tune_store_pkg.sv
package tune_store_pkg;
  localparam int CELL_W    = 32;
  localparam int RELAY_W   = 30;
  localparam int VALID_BIT = 31;
  localparam int BYTES_PER_CELL = CELL_W / 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WRITE,
    ST_READ,
    ST_DECIDE
  } ts_state_e;
endpackage

// File: rtl/ts_byte_mem.sv
module ts_byte_mem #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem_q [DEPTH];

  // Erased state is all ones: every cell reads as "no data".
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (we) begin
      mem_q[addr] <= wdata;
    end
  end

  assign rdata = mem_q[addr];
endmodule

// File: rtl/ts_pick.sv
module ts_pick
  import tune_store_pkg::*;
#(
  parameter int ANT_N = 4,
  localparam int ANT_W = $clog2(ANT_N)
) (
  input  logic [ANT_N-1:0][CELL_W-1:0] cells,
  input  logic [ANT_W-1:0]             last_ant,
  output logic                         hit,
  output logic [ANT_W-1:0]             ant,
  output logic [RELAY_W-1:0]           relay
);
  logic [ANT_N-1:0] vld;

  for (genvar a = 0; a < ANT_N; a++) begin : g_vld
    assign vld[a] = ~cells[a][VALID_BIT];
  end

  always_comb begin
    hit = |vld;
    ant = '0;
    for (int a = ANT_N - 1; a >= 0; a--) begin
      if (vld[a]) ant = ANT_W'(a);
    end
    if (vld[last_ant]) ant = last_ant;
    relay = hit ? cells[ant][RELAY_W-1:0] : '0;
  end
endmodule

// File: rtl/ts_ctrl.sv
module ts_ctrl
  import tune_store_pkg::*;
#(
  parameter int SEG_N = 16,
  parameter int ANT_N = 4,
  localparam int SEG_W = $clog2(SEG_N),
  localparam int ANT_W = $clog2(ANT_N),
  localparam int IDX_N = ANT_N * BYTES_PER_CELL,
  localparam int IDX_W = $clog2(IDX_N),
  localparam int AW    = $clog2(SEG_N * IDX_N)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         lk_start,
  input  logic [SEG_W-1:0]             lk_seg,
  input  logic                         wr_start,
  input  logic [SEG_W-1:0]             wr_seg,
  input  logic [ANT_W-1:0]             wr_ant,
  input  logic [RELAY_W-1:0]           wr_relay,
  output logic                         mem_we,
  output logic [AW-1:0]                mem_addr,
  output logic [7:0]                   mem_wdata,
  input  logic [7:0]                   mem_rdata,
  output logic [ANT_N-1:0][CELL_W-1:0] cells,
  output logic [ANT_W-1:0]             last_ant,
  input  logic                         pick_hit,
  input  logic [ANT_W-1:0]             pick_ant,
  input  logic [RELAY_W-1:0]           pick_relay,
  output logic                         busy,
  output logic                         done,
  output logic [ANT_W-1:0]             hit_ant,
  output logic [RELAY_W-1:0]           hit_relay,
  output logic                         miss
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(IDX_N - 1);

  ts_state_e                    st_q, st_d;
  logic [IDX_W-1:0]             cnt_q, cnt_d;
  logic [SEG_W-1:0]             seg_q, seg_d;
  logic [ANT_W-1:0]             ant_q, ant_d;
  logic [RELAY_W-1:0]           rly_q, rly_d;
  logic [ANT_W-1:0]             last_q, last_d;
  logic [ANT_N-1:0][CELL_W-1:0] cells_q, cells_d;
  logic                         done_q, done_d;
  logic [ANT_W-1:0]             hant_q, hant_d;
  logic [RELAY_W-1:0]           hrly_q, hrly_d;
  logic                         miss_q, miss_d;
  logic [CELL_W-1:0]            wr_word;

  assign wr_word = {1'b0, 1'b0, rly_q};

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    seg_d   = seg_q;
    ant_d   = ant_q;
    rly_d   = rly_q;
    last_d  = last_q;
    cells_d = cells_q;
    done_d  = 1'b0;
    hant_d  = hant_q;
    hrly_d  = hrly_q;
    miss_d  = miss_q;
    mem_we  = 1'b0;
    mem_wdata = wr_word[8*cnt_q[1:0] +: 8];
    if (st_q == ST_WRITE)
      mem_addr = AW'((int'(seg_q) * ANT_N + int'(ant_q)) * BYTES_PER_CELL
                     + int'(cnt_q[1:0]));
    else
      mem_addr = AW'(int'(seg_q) * IDX_N + int'(cnt_q));

    case (st_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (wr_start) begin
          st_d   = ST_WRITE;
          seg_d  = wr_seg;
          ant_d  = wr_ant;
          rly_d  = wr_relay;
          last_d = wr_ant;
        end else if (lk_start) begin
          st_d  = ST_READ;
          seg_d = lk_seg;
        end
      end
      ST_WRITE: begin
        mem_we = 1'b1;
        cnt_d  = cnt_q + IDX_W'(1);
        if (cnt_q[1:0] == 2'd3) st_d = ST_IDLE;
      end
      ST_READ: begin
        cells_d[cnt_q[IDX_W-1:2]][8*cnt_q[1:0] +: 8] = mem_rdata;
        cnt_d = cnt_q + IDX_W'(1);
        if (cnt_q == LAST_IDX) st_d = ST_DECIDE;
      end
      ST_DECIDE: begin
        done_d = 1'b1;
        hant_d = pick_hit ? pick_ant : '0;
        hrly_d = pick_relay;
        miss_d = ~pick_hit;
        if (pick_hit) last_d = pick_ant;
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      seg_q   <= '0;
      ant_q   <= '0;
      rly_q   <= '0;
      last_q  <= '0;
      cells_q <= '1;
      done_q  <= 1'b0;
      hant_q  <= '0;
      hrly_q  <= '0;
      miss_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      seg_q   <= seg_d;
      ant_q   <= ant_d;
      rly_q   <= rly_d;
      last_q  <= last_d;
      cells_q <= cells_d;
      done_q  <= done_d;
      hant_q  <= hant_d;
      hrly_q  <= hrly_d;
      miss_q  <= miss_d;
    end
  end

  assign cells     = cells_q;
  assign last_ant  = last_q;
  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign hit_ant   = hant_q;
  assign hit_relay = hrly_q;
  assign miss      = miss_q;
endmodule

// File: rtl/tune_store.sv
module tune_store
  import tune_store_pkg::*;
#(
  parameter int SEG_N = 16,
  parameter int ANT_N = 4,
  localparam int SEG_W = $clog2(SEG_N),
  localparam int ANT_W = $clog2(ANT_N),
  localparam int DEPTH = SEG_N * ANT_N * BYTES_PER_CELL,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_start,
  input  logic [SEG_W-1:0]   lk_seg,
  input  logic               wr_start,
  input  logic [SEG_W-1:0]   wr_seg,
  input  logic [ANT_W-1:0]   wr_ant,
  input  logic [RELAY_W-1:0] wr_relay,
  output logic               busy,
  output logic               done,
  output logic [ANT_W-1:0]   hit_ant,
  output logic [RELAY_W-1:0] hit_relay,
  output logic               miss
);
  logic                         mem_we;
  logic [AW-1:0]                mem_addr;
  logic [7:0]                   mem_wdata, mem_rdata;
  logic [ANT_N-1:0][CELL_W-1:0] cells;
  logic [ANT_W-1:0]             last_ant;
  logic                         pick_hit;
  logic [ANT_W-1:0]             pick_ant;
  logic [RELAY_W-1:0]           pick_relay;

  ts_byte_mem #(.DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .addr(mem_addr),
    .wdata(mem_wdata), .rdata(mem_rdata)
  );

  ts_pick #(.ANT_N(ANT_N)) u_pick (
    .cells(cells), .last_ant(last_ant),
    .hit(pick_hit), .ant(pick_ant), .relay(pick_relay)
  );

  ts_ctrl #(.SEG_N(SEG_N), .ANT_N(ANT_N)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .lk_start(lk_start), .lk_seg(lk_seg),
    .wr_start(wr_start), .wr_seg(wr_seg), .wr_ant(wr_ant), .wr_relay(wr_relay),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .cells(cells), .last_ant(last_ant),
    .pick_hit(pick_hit), .pick_ant(pick_ant), .pick_relay(pick_relay),
    .busy(busy), .done(done), .hit_ant(hit_ant), .hit_relay(hit_relay), .miss(miss)
  );
endmodule

// File: rtl/tune_store_chk.sv
module tune_store_chk #(
  parameter int ANT_W   = 2,
  parameter int RELAY_W = 30
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_start,
  input logic               busy,
  input logic               done,
  input logic [ANT_W-1:0]   hit_ant,
  input logic [RELAY_W-1:0] hit_relay,
  input logic               miss
);
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));

  assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> (hit_relay == '0 && hit_ant == '0));

  assert_write_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_start && !busy) |=> busy);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(hit_relay) && $stable(hit_ant) && $stable(miss)));
endmodule

bind tune_store tune_store_chk #(.ANT_W(ANT_W), .RELAY_W(tune_store_pkg::RELAY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .busy(busy), .done(done),
  .hit_ant(hit_ant), .hit_relay(hit_relay), .miss(miss)
);

// File: tb/tune_store_tb.sv
`timescale 1ns/1ps
module tune_store_tb;
  localparam int SEG_N = 16;
  localparam int ANT_N = 4;
  localparam int SEG_W = 4;
  localparam int ANT_W = 2;

  logic clk, rst_n;
  logic lk_start, wr_start;
  logic [SEG_W-1:0] lk_seg, wr_seg;
  logic [ANT_W-1:0] wr_ant;
  logic [29:0] wr_relay;
  logic busy, done, miss;
  logic [ANT_W-1:0] hit_ant;
  logic [29:0] hit_relay;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  bit          m_vld [SEG_N][ANT_N];
  logic [29:0] m_rly [SEG_N][ANT_N];
  int          m_last;

  tune_store #(.SEG_N(SEG_N), .ANT_N(ANT_N)) u_dut (
    .clk(clk), .rst_n(rst_n), .lk_start(lk_start), .lk_seg(lk_seg),
    .wr_start(wr_start), .wr_seg(wr_seg), .wr_ant(wr_ant), .wr_relay(wr_relay),
    .busy(busy), .done(done), .hit_ant(hit_ant), .hit_relay(hit_relay), .miss(miss)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // expected choice: -1 means miss
  function automatic int exp_pick(input int seg);
    int c = -1;
    for (int a = ANT_N - 1; a >= 0; a--) if (m_vld[seg][a]) c = a;
    if (c >= 0 && m_vld[seg][m_last]) c = m_last;
    return c;
  endfunction

  task automatic do_write(input int seg, input int ant, input logic [29:0] r, input bit with_lk);
    @(negedge clk);
    wr_start = 1; wr_seg = SEG_W'(seg); wr_ant = ANT_W'(ant); wr_relay = r;
    lk_start = with_lk; lk_seg = SEG_W'(seg);
    @(negedge clk);
    wr_start = 0; lk_start = 0;
    chk(busy == 1, "R2 busy cycle 1", busy, 1);
    for (int i = 2; i <= 4; i++) begin
      @(negedge clk);
      chk(busy == 1, "R2 busy held", busy, 1);
    end
    @(negedge clk);
    chk(busy == 0, "R2 busy end", busy, 0);
    m_vld[seg][ant] = 1; m_rly[seg][ant] = r; m_last = ant;
  endtask

  task automatic do_lookup(input int seg, input bit intrude, input string tag);
    int e;
    logic [ANT_W-1:0] pa; logic [29:0] pr; logic pm;
    pa = hit_ant; pr = hit_relay; pm = miss;
    e = exp_pick(seg);
    @(negedge clk);
    lk_start = 1; lk_seg = SEG_W'(seg);
    for (int i = 1; i <= 17; i++) begin
      @(negedge clk);
      lk_start = 0; wr_start = 0;
      if (intrude && i == 5) begin
        wr_start = 1; lk_start = 1; wr_seg = SEG_W'(seg); wr_ant = 2'd1; wr_relay = 30'h2AAA_5555;
      end
      if (done !== 0 || busy !== 1) begin
        chk(0, "R3 busy/done during lookup", {busy, done}, 2'b10);
        break;
      end
      if (i == 16) chk(hit_relay == pr && hit_ant == pa && miss == pm, "R11 hold", hit_relay, pr);
    end
    @(negedge clk);
    chk(done == 1 && busy == 0, "R3 done timing", {busy, done}, 2'b01);
    if (e < 0) begin
      chk(miss == 1 && hit_relay == 0 && hit_ant == 0, {tag, " R7 miss"}, {miss, hit_relay}, {1'b1, 30'd0});
    end else begin
      chk(miss == 0 && hit_ant == ANT_W'(e), {tag, " ant"}, hit_ant, e);
      chk(hit_relay == m_rly[seg][e], {tag, " relay"}, hit_relay, m_rly[seg][e]);
      m_last = e;
    end
    pa = hit_ant; pr = hit_relay; pm = miss;
    @(negedge clk);
    chk(done == 0, "R3 single pulse", done, 0);
    chk(hit_relay == pr && hit_ant == pa && miss == pm, "R11 hold after", hit_relay, pr);
  endtask

  initial begin
    #(8 * 200000);
    chk(0, "watchdog", 0, 1);
    report();
  end

  initial begin
    int seg, ant;
    bit bad_done;
    void'($urandom(32'd20240611));
    for (int s = 0; s < SEG_N; s++)
      for (int a = 0; a < ANT_N; a++) begin m_vld[s][a] = 0; m_rly[s][a] = '0; end
    m_last = 0;
    rst_n = 0; lk_start = 0; wr_start = 0; lk_seg = '0; wr_seg = '0; wr_ant = '0; wr_relay = '0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && miss == 0 && hit_ant == 0 && hit_relay == 0,
        "R1 reset outputs", {busy, done, miss, hit_ant, hit_relay}, 0);
    rst_n = 1;
    @(negedge clk);
    do_lookup(3, 0, "R1 erased");
    // R4 single valid
    do_write(5, 2, 30'h1234567, 0);
    do_lookup(5, 0, "R4 single");
    // R5 last-used valid (write ant0 makes it last)
    do_write(5, 0, 30'h3ABCDEF0, 0);
    do_lookup(5, 0, "R5 last used");
    // R6 last-used not valid in segment -> lowest
    do_write(9, 3, 30'h0F0F0F0, 0);
    do_lookup(5, 0, "R6 lowest");
    // R8 last updated by lookup hit (now 0), then write 2 and miss keeps 2
    do_write(12, 2, 30'h111, 0);
    do_lookup(7, 0, "R8 miss");
    do_lookup(5, 0, "R8 last kept");
    // R12 overwrite
    do_write(5, 2, 30'h2222222, 0);
    do_lookup(5, 0, "R12 overwrite");
    // R9 intrusion during lookup: segment 6 ant1 must stay empty
    do_lookup(6, 1, "R9 intrude");
    do_lookup(6, 0, "R9 after intrude");
    // R10 both strobes from idle
    do_write(10, 1, 30'h3FFFFFFF, 1);
    bad_done = 0;
    repeat (20) begin @(negedge clk); if (done) bad_done = 1; end
    chk(!bad_done, "R10 lookup dropped", bad_done, 0);
    do_lookup(10, 0, "R10 write kept");
    // random mix
    for (int k = 0; k < 80; k++) begin
      seg = int'($urandom_range(0, 3));
      ant = int'($urandom_range(0, ANT_N - 1));
      if ($urandom_range(0, 2) == 0) do_write(seg, ant, 30'($urandom), 0);
      else do_lookup(seg, 0, "R4/R5/R6 random");
    end
    report();
  end
endmodule